// File: doc/BRIEF.md
# Conversion Sample FIFO with Inverted Status Flags

This block buffers converter results on their way to a host. Every conversion-done strobe writes one 16-bit result into the queue. Every host read strobe on the data register takes the oldest result off the queue and presents it on the read-data port. The default queue holds 1024 results.

The host watches an 8-bit status byte. Its fill indications use inverted polarity: the full and half-full bits read 0 when their condition is true. The sample-available bit reads 1 as soon as one result is waiting. The same byte also reflects the converter-busy input and reads back the programmed gain code. A level interrupt request stays high while at least half the queue is occupied.

There is no dedicated clear input. Software empties the queue by writing an enable bit of the control register as 0, then 1, then 0. A push that arrives while the queue is full is lost, and that loss is recorded in a sticky overflow indication.

Top module: `sfifo_top`

## Requirements
- R1: After reset the status byte reads 0x60 while `cvt_busy` is low: bit 6 = 1, bit 5 = 1, bit 4 = 0, gain field 0. `irq_hf` and `overflow` are 0.
- R2: Results leave in the order they were pushed. `rd_data` takes the popped value on the clock edge that samples `data_rd`.
- R3: Status bit 4 reads 1 exactly when the queue holds at least one result.
- R4: Status bit 5 reads 0 and `irq_hf` reads 1 exactly when occupancy is at least 512. Both return to their idle values once occupancy falls to 511.
- R5: Status bit 6 reads 0 exactly when occupancy equals 1024.
- R6: A push while full with no pop in the same cycle is dropped and the stored contents stay unchanged. `overflow` then goes high and stays high until the next flush.
- R7: A pop while empty leaves `rd_data` at the last value read and moves no pointer. A later push and pop return the newly pushed value.
- R8: A control write is a cycle with `ctrl_wr` high; its bit 2 is the enable bit. A write with bit 2 = 0 arms the detector. A later write with bit 2 = 1 primes it, and repeated 1s keep it primed. The next write with bit 2 = 0 empties the queue on that edge, clears `overflow` and leaves the detector armed. After reset the detector is not armed, so a plain 1-then-0 does not flush.
- R9: Control bits other than bit 2 have no effect, and control writes that do not complete the R8 pattern leave the contents unchanged.
- R10: Status bits 2:0 return the gain code last written with `gain_wr` (reset value 0). Bit 3 reads 0. Bit 7 follows `cvt_busy`.
- R11: A push and a pop in the same cycle while full both take effect, and the queue stays full.
- R12: On the edge that completes a flush, a push in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cvt_done | input | 1 | Conversion-done strobe, pushes `cvt_data` |
| cvt_data | input | 16 | Conversion result |
| cvt_busy | input | 1 | Converter busy, reflected in status bit 7 |
| data_rd | input | 1 | Host read strobe of the data register, pops one result |
| rd_data | output | 16 | Last popped result |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 2 is the flush enable bit |
| gain_wr | input | 1 | Gain code write strobe |
| gain_wdata | input | 3 | Gain code |
| status | output | 8 | Status byte: busy, full_n, half_n, available, 0, gain |
| irq_hf | output | 1 | Half-full level interrupt request |
| overflow | output | 1 | Sticky lost-push indication |

## Verification
A wrong occupancy count shows at the ports at once: the inverted flags and `irq_hf` are decoded from it without delay, so the error is visible in the cycle after the faulty edge. The interesting points are the transitions at 511/512 and 1023/1024. A pointer or wrap fault does not disturb the flags. It shows only as a wrong popped value, possibly a full queue depth later, so the bench drains a completely filled queue and compares every word. A flush detector in the wrong state shows at the first control write that should or should not empty the queue.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    // status byte layout: host software decodes these positions
    localparam int ST_BUSY   = 7;
    localparam int ST_FULL_N = 6;
    localparam int ST_HALF_N = 5;
    localparam int ST_AVAIL  = 4;
    localparam int ST_RSVD   = 3;

    typedef enum logic [1:0] {
        FL_IDLE   = 2'd0,
        FL_ARMED  = 2'd1,
        FL_PRIMED = 2'd2
    } flush_st_e;
endpackage

// File: rtl/sfifo_flush_det.sv
module sfifo_flush_det
    import sfifo_pkg::*;
#(
    parameter int CTRL_W    = 8,
    parameter int FLUSH_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              flush
);
    flush_st_e st_d, st_q;
    logic      en_bit;
    logic      ctrl_unused;

    assign en_bit      = ctrl_wdata[FLUSH_BIT];
    assign ctrl_unused = ^(ctrl_wdata & ~(CTRL_W'(1) << FLUSH_BIT));

    always_comb begin
        st_d  = st_q;
        flush = 1'b0;
        if (ctrl_wr) begin
            unique case (st_q)
                FL_IDLE:   st_d = en_bit ? FL_IDLE : FL_ARMED;
                FL_ARMED:  st_d = en_bit ? FL_PRIMED : FL_ARMED;
                FL_PRIMED: begin
                    if (en_bit) begin
                        st_d = FL_PRIMED;
                    end else begin
                        st_d  = FL_ARMED;
                        flush = 1'b1;
                    end
                end
                default:   st_d = FL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [CNT_W-1:0]  cnt;
        logic              ovf;
        logic [DATA_W-1:0] dout;
    } store_t;

    store_t             s_d, s_q;
    logic [DATA_W-1:0]  mem [DEPTH];
    logic               full, empty, pop_ok, push_ok;

    assign full    = (s_q.cnt == CNT_W'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok) && !flush;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.wptr = '0;
            s_d.rptr = '0;
            s_d.cnt  = '0;
            s_d.ovf  = 1'b0;
        end else begin
            if (push_ok) s_d.wptr = s_q.wptr + 1'b1;
            if (pop_ok) begin
                s_d.rptr = s_q.rptr + 1'b1;
                s_d.dout = mem[s_q.rptr];
            end
            if (push_ok && !pop_ok)      s_d.cnt = s_q.cnt + 1'b1;
            else if (pop_ok && !push_ok) s_d.cnt = s_q.cnt - 1'b1;
            if (push && !push_ok)        s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wptr] <= din;
    end

    assign dout  = s_q.dout;
    assign count = s_q.cnt;
    assign ovf   = s_q.ovf;
endmodule

// File: rtl/sfifo_status.sv
module sfifo_status
    import sfifo_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int GAIN_W = 3,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int HALF  = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gain_wr,
    input  logic [GAIN_W-1:0] gain_wdata,
    input  logic              cvt_busy,
    input  logic [CNT_W-1:0]  count,
    output logic [7:0]        status,
    output logic              irq_hf
);
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } gain_t;

    gain_t g_d, g_q;
    logic  at_half, at_full, has_data;

    always_comb begin
        g_d = g_q;
        if (gain_wr) g_d.gain = gain_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign at_half  = (count >= CNT_W'(HALF));
    assign at_full  = (count == CNT_W'(DEPTH));
    assign has_data = (count != '0);

    always_comb begin
        status             = '0;
        status[GAIN_W-1:0] = g_q.gain;
        status[ST_RSVD]    = 1'b0;
        status[ST_AVAIL]   = has_data;
        status[ST_HALF_N]  = !at_half;
        status[ST_FULL_N]  = !at_full;
        status[ST_BUSY]    = cvt_busy;
    end

    assign irq_hf = at_half;
endmodule

// File: rtl/sfifo_top.sv
module sfifo_top #(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 1024,
    parameter int CTRL_W    = 8,
    parameter int FLUSH_BIT = 2,
    parameter int GAIN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cvt_done,
    input  logic [DATA_W-1:0] cvt_data,
    input  logic              cvt_busy,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              gain_wr,
    input  logic [GAIN_W-1:0] gain_wdata,
    output logic [7:0]        status,
    output logic              irq_hf,
    output logic              overflow
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             flush;
    logic [CNT_W-1:0] count;

    sfifo_flush_det #(.CTRL_W(CTRL_W), .FLUSH_BIT(FLUSH_BIT)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .flush      (flush)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (cvt_done),
        .din   (cvt_data),
        .pop   (data_rd),
        .dout  (rd_data),
        .count (count),
        .ovf   (overflow)
    );

    sfifo_status #(.DEPTH(DEPTH), .GAIN_W(GAIN_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .gain_wr    (gain_wr),
        .gain_wdata (gain_wdata),
        .cvt_busy   (cvt_busy),
        .count      (count),
        .status     (status),
        .irq_hf     (irq_hf)
    );
endmodule

// File: rtl/sfifo_top_chk.sv
module sfifo_top_chk #(
    parameter int DATA_W = 16,
    parameter int CTRL_W = 8,
    parameter int GAIN_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cvt_done,
    input logic [DATA_W-1:0] cvt_data,
    input logic              cvt_busy,
    input logic              data_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic              ctrl_wr,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic              gain_wr,
    input logic [GAIN_W-1:0] gain_wdata,
    input logic [7:0]        status,
    input logic              irq_hf,
    input logic              overflow
);
    AST_PUSH_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_done && !ctrl_wr) |=> status[4]); // R3
    AST_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !status[4] |-> (status[6] && status[5] && !irq_hf)); // R5
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[6] && cvt_done && !data_rd && !ctrl_wr) |=> !status[6]); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ctrl_wr) |=> overflow); // R6
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[4] && data_rd) |=> $stable(rd_data)); // R7
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_wr |=> $stable(status[2:0])); // R10
endmodule

bind sfifo_top sfifo_top_chk #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .GAIN_W(GAIN_W)) u_chk (.*);

// File: tb/tb_sfifo_top.sv
`timescale 1ns/1ps
module tb_sfifo_top;
    localparam int DEPTH = 1024;
    localparam int HALF  = 512;
    localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_CTRL = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] din;
        logic [7:0]  cw;
        logic        exp_avail;
        logic        chk_rd;
        logic [15:0] exp_rd;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{OP_PUSH, 16'hA1A1, 8'h00, 1'b1, 1'b0, 16'h0000},
        '{OP_PUSH, 16'hB2B2, 8'h00, 1'b1, 1'b0, 16'h0000},
        '{OP_POP,  16'h0000, 8'h00, 1'b1, 1'b1, 16'hA1A1},
        '{OP_POP,  16'h0000, 8'h00, 1'b0, 1'b1, 16'hB2B2},
        '{OP_POP,  16'h0000, 8'h00, 1'b0, 1'b1, 16'hB2B2},
        '{OP_PUSH, 16'hC3C3, 8'h00, 1'b1, 1'b0, 16'h0000},
        '{OP_CTRL, 16'h0000, 8'h00, 1'b1, 1'b0, 16'h0000},
        '{OP_CTRL, 16'h0000, 8'hFB, 1'b1, 1'b0, 16'h0000},
        '{OP_CTRL, 16'h0000, 8'h04, 1'b1, 1'b0, 16'h0000},
        '{OP_CTRL, 16'h0000, 8'h04, 1'b1, 1'b0, 16'h0000},
        '{OP_CTRL, 16'h0000, 8'hFB, 1'b0, 1'b0, 16'h0000},
        '{OP_POP,  16'h0000, 8'h00, 1'b0, 1'b1, 16'hB2B2},
        '{OP_PUSH, 16'hD4D4, 8'h00, 1'b1, 1'b0, 16'h0000},
        '{OP_POP,  16'h0000, 8'h00, 1'b0, 1'b1, 16'hD4D4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cvt_done = 1'b0;
    logic [15:0] cvt_data = '0;
    logic        cvt_busy = 1'b0;
    logic        data_rd = 1'b0;
    logic [15:0] rd_data;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        gain_wr = 1'b0;
    logic [2:0]  gain_wdata = '0;
    logic [7:0]  status;
    logic        irq_hf;
    logic        overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sfifo_top dut (
        .clk(clk), .rst_n(rst_n), .cvt_done(cvt_done), .cvt_data(cvt_data),
        .cvt_busy(cvt_busy), .data_rd(data_rd), .rd_data(rd_data),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .gain_wr(gain_wr),
        .gain_wdata(gain_wdata), .status(status), .irq_hf(irq_hf),
        .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, hold across one rising edge, release at the next falling edge
    task automatic step(input logic push, input logic [15:0] d, input logic pop,
                        input logic cwr, input logic [7:0] cw);
        cvt_done   = push;
        cvt_data   = d;
        data_rd    = pop;
        ctrl_wr    = cwr;
        ctrl_wdata = cw;
        @(negedge clk);
        cvt_done = 1'b0;
        data_rd  = 1'b0;
        ctrl_wr  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        check("R1 status", {24'd0, status}, 32'h60);
        check("R1 irq_hf", {31'd0, irq_hf}, 0);
        check("R1 overflow", {31'd0, overflow}, 0);

        // table walk: R2 R3 R7 R8 R9 R12
        foreach (VEC[i]) begin
            step(VEC[i].op == OP_PUSH, VEC[i].din, VEC[i].op == OP_POP,
                 VEC[i].op == OP_CTRL, VEC[i].cw);
            check($sformatf("R3/R8/R9 vec%0d avail", i), {31'd0, status[4]}, {31'd0, VEC[i].exp_avail});
            if (VEC[i].chk_rd)
                check($sformatf("R2/R7 vec%0d rd_data", i), {16'd0, rd_data}, {16'd0, VEC[i].exp_rd});
        end

        // R12: push during completing flush write is dropped (detector armed after table)
        step(1'b1, 16'h1111, 1'b0, 1'b0, 8'h00);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h04);
        step(1'b1, 16'h2222, 1'b0, 1'b1, 8'h00);
        check("R12 avail after flush with push", {31'd0, status[4]}, 0);

        // R10: gain readback, reserved bit, busy mirror
        gain_wdata = 3'd5;
        gain_wr    = 1'b1;
        cvt_busy   = 1'b1;
        @(negedge clk);
        gain_wr = 1'b0;
        check("R10 gain field", {29'd0, status[2:0]}, 5);
        check("R10 bit3", {31'd0, status[3]}, 0);
        check("R10 busy", {31'd0, status[7]}, 1);
        cvt_busy = 1'b0;
        @(negedge clk);
        check("R10 busy low", {31'd0, status[7]}, 0);

        // R4 R5: fill the whole queue
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 16'h1000 + 16'(k), 1'b0, 1'b0, 8'h00);
            if (k == HALF - 2) begin
                check("R4 half_n at 511", {31'd0, status[5]}, 1);
                check("R4 irq at 511", {31'd0, irq_hf}, 0);
            end
            if (k == HALF - 1) begin
                check("R4 half_n at 512", {31'd0, status[5]}, 0);
                check("R4 irq at 512", {31'd0, irq_hf}, 1);
            end
            if (k == DEPTH - 2) check("R5 full_n at 1023", {31'd0, status[6]}, 1);
        end
        check("R5 full_n at 1024", {31'd0, status[6]}, 0);
        check("R6 overflow before", {31'd0, overflow}, 0);

        // R6: push while full is dropped
        step(1'b1, 16'hDEAD, 1'b0, 1'b0, 8'h00);
        check("R6 overflow set", {31'd0, overflow}, 1);
        check("R6 still full", {31'd0, status[6]}, 0);

        // R11: simultaneous push and pop when full
        step(1'b1, 16'hBEEF, 1'b1, 1'b0, 8'h00);
        check("R11 rd_data", {16'd0, rd_data}, 32'h1000);
        check("R11 still full", {31'd0, status[6]}, 0);

        // drain: R2 order, R4 deassert, R6 stickiness
        for (int k = 1; k < DEPTH; k++) begin
            step(1'b0, 16'h0000, 1'b1, 1'b0, 8'h00);
            check("R2 drain order", {16'd0, rd_data}, {16'd0, 16'h1000 + 16'(k)});
            if (k == HALF) check("R4 irq at 512 left", {31'd0, irq_hf}, 1);
            if (k == HALF + 1) begin
                check("R4 irq at 511 left", {31'd0, irq_hf}, 0);
                check("R4 half_n at 511 left", {31'd0, status[5]}, 1);
            end
        end
        step(1'b0, 16'h0000, 1'b1, 1'b0, 8'h00);
        check("R6 dropped word absent", {16'd0, rd_data}, 32'hBEEF);
        check("R3 empty after drain", {31'd0, status[4]}, 0);
        check("R6 overflow sticky", {31'd0, overflow}, 1);

        // R8: flush clears overflow
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h04);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h00);
        check("R8 overflow cleared", {31'd0, overflow}, 0);

        // R8: after reset a plain 1-then-0 does not flush
        do_reset();
        step(1'b1, 16'h5555, 1'b0, 1'b0, 8'h00);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h04);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h00);
        check("R8 unarmed no flush", {31'd0, status[4]}, 1);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h04);
        step(1'b0, 16'h0000, 1'b0, 1'b1, 8'h00);
        check("R8 armed flush", {31'd0, status[4]}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule